// File: doc/BRIEF.md
# Byte-Strobed Serializer with Internal Loopback

This block turns a 10-bit parallel word into a serial bit stream. It runs entirely in one bit-clock domain. A byte strobe, asserted for one bit-clock cycle, marks the moment a new word is captured. At the nominal rate the strobe fires once every ten bit clocks, and the word then leaves one bit per clock, bit 0 first.

The serial stream can go to one of two places. In normal operation it drives a differential line output (`line_p`, `line_n`). In that mode the receive-side stream `rx_serial` follows the external line input `line_in`. When `lb_en` is high, the stream goes instead to `lpbk_out` and to `rx_serial`. The line output is then parked with `line_p` low and `line_n` high, and `line_in` is ignored.

The core is a two-state machine.

- **ST_IDLE** outputs a constant 0.
- **ST_SHIFT** outputs the current word bit by bit.

Its transitions are:

- **LOAD**: a strobe in either state moves the machine to ST_SHIFT and captures the word.
- **DRAIN_END**: in ST_SHIFT, after the tenth bit with no strobe, the machine returns to ST_IDLE.

Top module: `sertx_loopback`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears its state. After that edge the serial stream is 0, so `line_p`=0, `line_n`=1, `lpbk_out`=0, and with `lb_en`=0 `rx_serial` equals `line_in`.
- R2: A word on `tx_word` is captured at the rising edge where `byte_stb`=1. Its bit 0 appears on the serial stream in the cycle that follows that edge.
- R3: After a capture with no further strobe, bit k of the captured word is on the stream during the k-th cycle after the capture cycle, for k = 0..9 (least significant bit first).
- R4: Strobes spaced exactly 10 cycles apart produce a continuous stream. No bit is dropped or repeated between words.
- R5: If no strobe arrives by the edge after bit 9, the machine takes DRAIN_END and the stream holds 0 until the next strobe.
- R6: A strobe arriving before bit 9 has been sent abandons the rest of the current word. The new word starts at its bit 0 in the next cycle.
- R7: While `lb_en`=1, `line_p`=0 and `line_n`=1 regardless of the data.
- R8: While `lb_en`=1, `lpbk_out` carries the serial stream. While `lb_en`=0, `lpbk_out`=0.
- R9: `rx_serial` equals the serial stream when `lb_en`=1, ignoring `line_in`. It equals `line_in` when `lb_en`=0.
- R10: While `lb_en`=0, `line_p` carries the serial stream and `line_n` is its complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_stb | input | 1 | One-cycle word capture strobe |
| tx_word | input | 10 | Parallel word to serialize |
| lb_en | input | 1 | Loopback enable |
| line_in | input | 1 | External serial input |
| line_p | output | 1 | Line output, true side |
| line_n | output | 1 | Line output, complement side |
| lpbk_out | output | 1 | Internal loopback serial output |
| rx_serial | output | 1 | Selected receive serial stream |

## Verification
A bit counter or shift register that goes wrong shows up at the ports in the very next cycle. It appears either as a misplaced or repeated bit inside a word, or as a stream that fails to fall to 0 once bit 9 has been sent.

A routing fault appears in the same cycle that `lb_en` changes. Such a fault might leak data onto the parked line, drop data from the loopback path, or pass `line_in` through during loopback. The bench therefore compares all four outputs every cycle against a model built from the requirements. It uses directed words, strobe spacings of 10, fewer than 10 and more than 10 cycles, and random toggling of loopback and line input.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } ser_state_e;
endpackage

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_stb,
    input  logic [WORD_W-1:0] word_in,
    output logic              ser_bit
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    ser_state_e        st_q, st_nxt;
    logic [WORD_W-1:0] sreg_q;
    logic [CNT_W-1:0]  cnt_q;

    // next-state: LOAD and DRAIN_END transitions
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (byte_stb) st_nxt = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (byte_stb)           st_nxt = ST_SHIFT;
                else if (cnt_q == LAST) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (byte_stb) begin
            sreg_q <= word_in;
            cnt_q  <= '0;
        end else if (st_q == ST_SHIFT) begin
            if (cnt_q == LAST) begin
                sreg_q <= '0;
                cnt_q  <= '0;
            end else begin
                sreg_q <= sreg_q >> 1;
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    // output process
    always_comb begin
        unique case (st_q)
            ST_IDLE:  ser_bit = 1'b0;
            ST_SHIFT: ser_bit = sreg_q[0];
            default:  ser_bit = 1'b0;
        endcase
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !ser_bit); // R1
    AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (rst)
        byte_stb |=> ser_bit == $past(word_in[0])); // R2
    AST_NEXT_BIT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SHIFT && cnt_q != LAST && !byte_stb) |=> ser_bit == $past(sreg_q[1])); // R3
    AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SHIFT && cnt_q == LAST && !byte_stb) |=> (st_q == ST_IDLE && !ser_bit)); // R5
endmodule

// File: rtl/sertx_line_ctl.sv
module sertx_line_ctl (
    input  logic lb_en,
    input  logic ser_bit,
    output logic line_p,
    output logic line_n,
    output logic lpbk_bit
);
    always_comb begin
        if (lb_en) begin
            line_p   = 1'b0;
            line_n   = 1'b1;
            lpbk_bit = ser_bit;
        end else begin
            line_p   = ser_bit;
            line_n   = ~ser_bit;
            lpbk_bit = 1'b0;
        end
    end
endmodule

// File: rtl/sertx_rx_sel.sv
module sertx_rx_sel (
    input  logic lb_en,
    input  logic lpbk_bit,
    input  logic line_in,
    output logic rx_bit
);
    always_comb rx_bit = lb_en ? lpbk_bit : line_in;
endmodule

// File: rtl/sertx_loopback.sv
module sertx_loopback #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_stb,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              lb_en,
    input  logic              line_in,
    output logic              line_p,
    output logic              line_n,
    output logic              lpbk_out,
    output logic              rx_serial
);
    logic ser_bit;
    logic lpbk_bit;

    sertx_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .byte_stb (byte_stb),
        .word_in  (tx_word),
        .ser_bit  (ser_bit)
    );

    sertx_line_ctl u_line (
        .lb_en    (lb_en),
        .ser_bit  (ser_bit),
        .line_p   (line_p),
        .line_n   (line_n),
        .lpbk_bit (lpbk_bit)
    );

    sertx_rx_sel u_rxsel (
        .lb_en    (lb_en),
        .lpbk_bit (lpbk_bit),
        .line_in  (line_in),
        .rx_bit   (rx_serial)
    );

    assign lpbk_out = lpbk_bit;

    AST_LB_LINE_PARK: assert property (@(posedge clk) disable iff (rst)
        lb_en |-> (!line_p && line_n)); // R7
    AST_LB_ROUTE: assert property (@(posedge clk) disable iff (rst)
        lb_en |-> (lpbk_out == ser_bit)); // R8
    AST_RX_SELECT: assert property (@(posedge clk) disable iff (rst)
        lb_en |-> (rx_serial == lpbk_out)); // R9
    AST_LINE_DIFF: assert property (@(posedge clk) disable iff (rst)
        !lb_en |-> (line_n != line_p && !lpbk_out)); // R10
endmodule

// File: tb/test_sertx_loopback.sv
module test_sertx_loopback;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_stb = 1'b0;
    logic [9:0] tx_word = '0;
    logic       lb_en = 1'b0;
    logic       line_in = 1'b0;
    logic       line_p, line_n, lpbk_out, rx_serial;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic [9:0] m_word = '0;
    int         m_idx = 0;
    bit         m_active = 0;

    always #2 clk = ~clk;

    sertx_loopback i_sertx_loopback (
        .clk(clk), .rst(rst), .byte_stb(byte_stb), .tx_word(tx_word),
        .lb_en(lb_en), .line_in(line_in), .line_p(line_p), .line_n(line_n),
        .lpbk_out(lpbk_out), .rx_serial(rx_serial)
    );

    function automatic logic [3:0] expect_out(logic bitv, logic l, logic li);
        return {l ? 1'b0 : bitv, l ? 1'b1 : ~bitv, l ? bitv : 1'b0, l ? bitv : li};
    endfunction

    task automatic step(input logic r, input logic s, input logic [9:0] w,
                        input logic l, input logic li, input string req);
        logic       bitv;
        logic [3:0] exp_v, act_v;
        @(negedge clk);
        rst = r; byte_stb = s; tx_word = w; lb_en = l; line_in = li;
        @(posedge clk);
        #1;
        if (r) begin
            m_active = 0; m_idx = 0; m_word = '0;
        end else if (s) begin
            m_active = 1; m_idx = 0; m_word = w;
        end else if (m_active) begin
            m_idx++;
            if (m_idx == 10) m_active = 0;
        end
        bitv  = m_active ? m_word[m_idx] : 1'b0;
        exp_v = expect_out(bitv, l, li);
        act_v = {line_p, line_n, lpbk_out, rx_serial};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: {p,n,lb,rx} actual=%b expected=%b", req, act_v, exp_v);
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [9:0] w;
        void'($urandom(32'd1234));
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1, 0, 10'h3FF, 0, 1, "R1");
        step(1, 1, 10'h3FF, 0, 0, "R1");
        // R2/R3: single word, then R5 drain to idle
        step(0, 1, 10'h2A5, 0, 0, "R2");
        for (int i = 1; i < 10; i++) step(0, 0, 10'h000, 0, i[0], "R3");
        for (int i = 0; i < 6; i++) step(0, 0, 10'h3FF, 0, 0, "R5");
        // R4: back-to-back words every 10 cycles
        for (int k = 0; k < 5; k++) begin
            w = 10'($urandom);
            step(0, 1, w, 0, 0, "R4");
            for (int i = 1; i < 10; i++) step(0, 0, 10'($urandom), 0, 0, "R4");
        end
        step(0, 0, 10'h000, 0, 0, "R5");
        // R6: early strobe restarts
        step(0, 1, 10'h3FF, 0, 0, "R6");
        for (int i = 0; i < 3; i++) step(0, 0, 10'h000, 0, 0, "R6");
        step(0, 1, 10'h155, 0, 0, "R6");
        for (int i = 1; i < 12; i++) step(0, 0, 10'h000, 0, 0, "R6");
        // R7/R8/R9: loopback with line input toggling
        step(0, 1, 10'h3C3, 1, 1, "R7");
        for (int i = 1; i < 10; i++) step(0, 0, 10'h000, 1, i[0], "R8");
        for (int i = 0; i < 4; i++) step(0, 0, 10'h000, 1, 1, "R9");
        // R10 / R9: random mix
        for (int i = 0; i < 400; i++) begin
            logic s, l;
            s = ($urandom % 8) == 0;
            l = ($urandom % 3) == 0;
            step(0, s, 10'($urandom), l, 1'($urandom), l ? "R9" : "R10");
        end
        // R1: reset in mid-word
        step(0, 1, 10'h3FF, 0, 0, "R2");
        step(1, 0, 10'h000, 0, 1, "R1");
        step(0, 0, 10'h000, 0, 0, "R1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule